// File: doc/BRIEF.md
# Three-Multiplier Complex Rotator

This block multiplies a complex data sample by a complex twiddle factor in signed fixed point. It is the rotation step that sits between the butterfly stages of a fast Fourier transform datapath. It forms the product with three real multipliers instead of four. The first term, data-real times the twiddle sum, feeds both outputs. Each output then takes one more product away from that shared term.

The datapath has three registered stages: operand pre-addition, multiplication, and post-subtraction with truncation. One sample enters per clock. A valid flag travels beside each sample, so a result leaves three clocks after its operands were taken. Twiddles are fractional numbers with `FRAC_W` fraction bits. The full-precision result is shifted right by `FRAC_W` and narrowed back to the input width without rounding.

Top module: `cmul3_rotator`

## Requirements
- R1: Before narrowing, the real result equals the exact integer smp_re·tw_re − smp_im·tw_im. It is formed as smp_re·(tw_re+tw_im) − (smp_re+smp_im)·tw_im.
- R2: Before narrowing, the imaginary result equals the exact integer smp_im·tw_re + smp_re·tw_im. It is formed as smp_re·(tw_re+tw_im) − (smp_re−smp_im)·tw_re.
- R3: out_re and out_im are bits [FRAC_W+DATA_W−1 : FRAC_W] of the exact results, that is an arithmetic right shift by FRAC_W (15 by default) that rounds toward minus infinity, followed by a wrap to DATA_W (16) bits.
- R4: The three pre-added operands are one bit wider than the inputs, so R1 to R3 hold for all input values, including −32768 on every input and +32767 on both twiddle parts.
- R5: out_vld is high exactly three clock cycles after in_vld was sampled high, and low otherwise. A new sample is accepted on every cycle.
- R6: While rst_n is low (active low, asynchronous), out_vld, out_re and out_im are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Marks a valid operand set |
| smp_re | input | DATA_W | Sample real part, signed |
| smp_im | input | DATA_W | Sample imaginary part, signed |
| tw_re | input | DATA_W | Twiddle real part, signed fraction |
| tw_im | input | DATA_W | Twiddle imaginary part, signed fraction |
| out_vld | output | 1 | Marks a valid result |
| out_re | output | DATA_W | Real result, truncated |
| out_im | output | DATA_W | Imaginary result, truncated |

## Verification
On every cycle that carries a valid sample, the embedded properties check two things. First, the registered product difference matches a four-multiplier direct product taken two cycles earlier. Second, the narrowed outputs match the slice of that direct product taken three cycles earlier. Each stage also checks that its valid flag steps forward by exactly one cycle. Only the bench scenarios can show the behaviours that need a history. These are the exact values at the extreme operands, results that depend on wrapping, streams with gaps between samples, and clearing the pipeline in the middle of a stream.

// File: rtl/cmul3_pkg.sv
package cmul3_pkg;
   localparam int DEF_DATA_W = 16;
   localparam int DEF_FRAC_W = 15;
   localparam int NUM_MULT   = 3;
endpackage

// File: rtl/cmul3_preadd.sv
module cmul3_preadd #(
   parameter int DATA_W = 16,
   localparam int PW    = DATA_W + 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     vld_i,
   input  logic signed [DATA_W-1:0] br_i,
   input  logic signed [DATA_W-1:0] bi_i,
   input  logic signed [DATA_W-1:0] wr_i,
   input  logic signed [DATA_W-1:0] wi_i,
   output logic                     vld_o,
   output logic signed [DATA_W-1:0] br_o,
   output logic signed [DATA_W-1:0] wr_o,
   output logic signed [DATA_W-1:0] wi_o,
   output logic signed [PW-1:0]     wsum_o,
   output logic signed [PW-1:0]     bsum_o,
   output logic signed [PW-1:0]     bdif_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o  <= 1'b0;
         br_o   <= '0;
         wr_o   <= '0;
         wi_o   <= '0;
         wsum_o <= '0;
         bsum_o <= '0;
         bdif_o <= '0;
      end else begin
         vld_o  <= vld_i;
         br_o   <= br_i;
         wr_o   <= wr_i;
         wi_o   <= wi_i;
         wsum_o <= PW'(wr_i) + PW'(wi_i);
         bsum_o <= PW'(br_i) + PW'(bi_i);
         bdif_o <= PW'(br_i) - PW'(bi_i);
      end
   end

   assert_valid_step_pre_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (vld_o == $past(vld_i)));
endmodule

// File: rtl/cmul3_mult.sv
module cmul3_mult
   import cmul3_pkg::*;
#(
   parameter int DATA_W = 16,
   localparam int PW    = DATA_W + 1,
   localparam int PRODW = 2 * PW
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     vld_i,
   input  logic signed [DATA_W-1:0] br_i,
   input  logic signed [DATA_W-1:0] wr_i,
   input  logic signed [DATA_W-1:0] wi_i,
   input  logic signed [PW-1:0]     wsum_i,
   input  logic signed [PW-1:0]     bsum_i,
   input  logic signed [PW-1:0]     bdif_i,
   output logic                     vld_o,
   output logic signed [PRODW-1:0]  p_shared_o,
   output logic signed [PRODW-1:0]  p_re_o,
   output logic signed [PRODW-1:0]  p_im_o
);
   logic signed [PW-1:0]    op_a [NUM_MULT];
   logic signed [PW-1:0]    op_b [NUM_MULT];
   logic signed [PRODW-1:0] prod [NUM_MULT];

   assign op_a[0] = PW'(br_i);
   assign op_b[0] = wsum_i;
   assign op_a[1] = bsum_i;
   assign op_b[1] = PW'(wi_i);
   assign op_a[2] = bdif_i;
   assign op_b[2] = PW'(wr_i);

   for (genvar g = 0; g < NUM_MULT; g++) begin : g_lane
      logic signed [PRODW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= PRODW'(op_a[g]) * PRODW'(op_b[g]);
      end
      assign prod[g] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_o <= 1'b0;
      else        vld_o <= vld_i;
   end

   assign p_shared_o = prod[0];
   assign p_re_o     = prod[1];
   assign p_im_o     = prod[2];

   assert_valid_step_mul_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (vld_o == $past(vld_i)));
endmodule

// File: rtl/cmul3_postsub.sv
module cmul3_postsub #(
   parameter int DATA_W = 16,
   parameter int FRAC_W = 15,
   localparam int PW    = DATA_W + 1,
   localparam int PRODW = 2 * PW
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     vld_i,
   input  logic signed [PRODW-1:0]  p_shared_i,
   input  logic signed [PRODW-1:0]  p_re_i,
   input  logic signed [PRODW-1:0]  p_im_i,
   output logic                     vld_o,
   output logic signed [DATA_W-1:0] re_o,
   output logic signed [DATA_W-1:0] im_o
);
   logic signed [PRODW-1:0] full_re, full_im;

   assign full_re = p_shared_i - p_re_i;
   assign full_im = p_shared_i - p_im_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o <= 1'b0;
         re_o  <= '0;
         im_o  <= '0;
      end else begin
         vld_o <= vld_i;
         re_o  <= full_re[FRAC_W+DATA_W-1:FRAC_W];
         im_o  <= full_im[FRAC_W+DATA_W-1:FRAC_W];
      end
   end

   assert_valid_step_post_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (vld_o == $past(vld_i)));
endmodule

// File: rtl/cmul3_rotator.sv
module cmul3_rotator
   import cmul3_pkg::*;
#(
   parameter int DATA_W = DEF_DATA_W,
   parameter int FRAC_W = DEF_FRAC_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_vld,
   input  logic signed [DATA_W-1:0] smp_re,
   input  logic signed [DATA_W-1:0] smp_im,
   input  logic signed [DATA_W-1:0] tw_re,
   input  logic signed [DATA_W-1:0] tw_im,
   output logic                     out_vld,
   output logic signed [DATA_W-1:0] out_re,
   output logic signed [DATA_W-1:0] out_im
);
   localparam int PW    = DATA_W + 1;
   localparam int PRODW = 2 * PW;

   if (DATA_W < 2) begin : g_bad_width
      $error("cmul3_rotator: DATA_W must be at least 2");
   end
   if (FRAC_W < 1 || FRAC_W + DATA_W > PRODW) begin : g_bad_frac
      $error("cmul3_rotator: FRAC_W out of range for DATA_W");
   end

   logic                     s1_vld;
   logic signed [DATA_W-1:0] s1_br, s1_wr, s1_wi;
   logic signed [PW-1:0]     s1_wsum, s1_bsum, s1_bdif;
   logic                     s2_vld;
   logic signed [PRODW-1:0]  s2_shared, s2_re, s2_im;

   cmul3_preadd #(.DATA_W(DATA_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld_i  (in_vld),
      .br_i   (smp_re),
      .bi_i   (smp_im),
      .wr_i   (tw_re),
      .wi_i   (tw_im),
      .vld_o  (s1_vld),
      .br_o   (s1_br),
      .wr_o   (s1_wr),
      .wi_o   (s1_wi),
      .wsum_o (s1_wsum),
      .bsum_o (s1_bsum),
      .bdif_o (s1_bdif)
   );

   cmul3_mult #(.DATA_W(DATA_W)) u_mul (
      .clk        (clk),
      .rst_n      (rst_n),
      .vld_i      (s1_vld),
      .br_i       (s1_br),
      .wr_i       (s1_wr),
      .wi_i       (s1_wi),
      .wsum_i     (s1_wsum),
      .bsum_i     (s1_bsum),
      .bdif_i     (s1_bdif),
      .vld_o      (s2_vld),
      .p_shared_o (s2_shared),
      .p_re_o     (s2_re),
      .p_im_o     (s2_im)
   );

   cmul3_postsub #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_post (
      .clk        (clk),
      .rst_n      (rst_n),
      .vld_i      (s2_vld),
      .p_shared_i (s2_shared),
      .p_re_i     (s2_re),
      .p_im_i     (s2_im),
      .vld_o      (out_vld),
      .re_o       (out_re),
      .im_o       (out_im)
   );

   // Four-multiplier direct form, used only by the properties below.
   logic signed [PRODW-1:0] dir_re, dir_im;
   assign dir_re = PRODW'(smp_re) * PRODW'(tw_re) - PRODW'(smp_im) * PRODW'(tw_im);
   assign dir_im = PRODW'(smp_im) * PRODW'(tw_re) + PRODW'(smp_re) * PRODW'(tw_im);

   assert_real_exact_R1: assert property (@(posedge clk) disable iff (!rst_n)
      s2_vld |-> ((s2_shared - s2_re) == $past(dir_re, 2)));

   assert_imag_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
      s2_vld |-> ((s2_shared - s2_im) == $past(dir_im, 2)));

   assert_out_re_trunc_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (out_re == $past(dir_re[FRAC_W+DATA_W-1:FRAC_W], 3)));

   assert_out_im_trunc_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (out_im == $past(dir_im[FRAC_W+DATA_W-1:FRAC_W], 3)));
endmodule

// File: tb/tb_cmul3_rotator.sv
module tb_cmul3_rotator;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int FW = 15;
   localparam int NVEC = 12;

   // Each entry packs {smp_re, smp_im, tw_re, tw_im}.
   localparam logic [63:0] VEC [NVEC] = '{
      64'h8000_8000_8000_8000,
      64'h7FFF_7FFF_7FFF_7FFF,
      64'h7FFF_8000_7FFF_7FFF,
      64'h8000_7FFF_8000_8000,
      64'h1234_5678_7FFF_0000,
      64'h1234_5678_0000_8000,
      64'h0000_0000_0000_0000,
      64'hFFFF_FFFF_0001_0001,
      64'h4000_C000_5A82_A57E,
      64'h0001_0000_0001_0000,
      64'h8000_0000_8000_0000,
      64'hABCD_1357_3FFF_C001
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_vld = 1'b0;
   logic signed [DW-1:0] smp_re = '0, smp_im = '0, tw_re = '0, tw_im = '0;
   logic out_vld;
   logic signed [DW-1:0] out_re, out_im;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   logic          mv  [3];
   logic [DW-1:0] mre [3];
   logic [DW-1:0] mim [3];
   string         mtag[3];

   always #(CLK_PERIOD/2) clk = ~clk;

   cmul3_rotator dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
      .smp_re(smp_re), .smp_im(smp_im), .tw_re(tw_re), .tw_im(tw_im),
      .out_vld(out_vld), .out_re(out_re), .out_im(out_im)
   );

   task automatic ref_calc(input logic signed [DW-1:0] br, bi, wr, wi,
                           output logic [DW-1:0] re, im);
      longint fr, fi;
      fr = longint'(br) * longint'(wr) - longint'(bi) * longint'(wi);
      fi = longint'(bi) * longint'(wr) + longint'(br) * longint'(wi);
      re = DW'(fr >>> FW);
      im = DW'(fi >>> FW);
   endtask

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic clear_model();
      for (int i = 0; i < 3; i++) begin
         mv[i] = 1'b0; mre[i] = '0; mim[i] = '0; mtag[i] = "";
      end
   endtask

   // One cycle: check the output due now, then drive the next operand set.
   task automatic step(input logic v, input logic [DW-1:0] br, bi, wr, wi, input string tag);
      logic [DW-1:0] er, ei;
      @(negedge clk);
      chk("R5 out_vld", DW'(out_vld), DW'(mv[2]));
      if (mv[2]) begin
         chk({mtag[2], " R1 R3 real"}, out_re, mre[2]);
         chk({mtag[2], " R2 R3 imag"}, out_im, mim[2]);
      end
      ref_calc(br, bi, wr, wi, er, ei);
      for (int i = 2; i > 0; i--) begin
         mv[i] = mv[i-1]; mre[i] = mre[i-1]; mim[i] = mim[i-1]; mtag[i] = mtag[i-1];
      end
      mv[0] = v; mre[0] = er; mim[0] = ei; mtag[0] = tag;
      in_vld = v; smp_re = br; smp_im = bi; tw_re = wr; tw_im = wi;
   endtask

   task automatic flush();
      for (int i = 0; i < 3; i++) step(1'b0, '0, '0, '0, '0, "idle");
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   initial begin
      clear_model();
      // R6: reset state
      repeat (3) @(negedge clk);
      chk("R6 out_vld in reset", DW'(out_vld), '0);
      chk("R6 out_re in reset", out_re, '0);
      chk("R6 out_im in reset", out_im, '0);
      rst_n = 1'b1;

      // Table walk, back to back; corner entries exercise R4
      for (int k = 0; k < NVEC; k++)
         step(1'b1, VEC[k][63:48], VEC[k][47:32], VEC[k][31:16], VEC[k][15:0],
              $sformatf("R4 vec%0d", k));
      flush();

      // Random stream with gaps
      for (int k = 0; k < 200; k++)
         step(1'(($urandom % 4) != 0), DW'($urandom), DW'($urandom),
              DW'($urandom), DW'($urandom), "rand");
      flush();

      // R5: an isolated pulse appears after exactly three cycles
      step(1'b1, 16'h7FFF, 16'h8000, 16'h8000, 16'h7FFF, "R5 pulse");
      for (int i = 0; i < 5; i++) step(1'b0, '0, '0, '0, '0, "idle");

      // R6: reset in the middle of a stream clears the pipeline
      for (int i = 0; i < 2; i++) step(1'b1, 16'h2222, 16'h3333, 16'h4444, 16'h5555, "pre-reset");
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R6 out_vld after mid-stream reset", DW'(out_vld), '0);
      chk("R6 out_re after mid-stream reset", out_re, '0);
      @(negedge clk);
      chk("R6 out_vld held in reset", DW'(out_vld), '0);
      in_vld = 1'b0;
      clear_model();
      rst_n = 1'b1;
      flush();
      flush();

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end
endmodule